// File: doc/BRIEF.md
# Card Bus Clock Divider Controller

This block derives the clock that drives a memory card bus from a fixed reference clock (nominally 96 MHz) by an integer divisor. Software controls it through one control word that holds an internal-clock enable, a bus-clock enable, the divisor and a data/busy timeout code. The block reports back an internal-clock-stable flag. Typical settings are a divisor of 240 for the 400 kHz identification phase, 4 for roughly 24 MHz and 2 for roughly 48 MHz.

Every change of frequency runs through a fixed hardware sequence. The running bus clock is first stopped, and only during its low phase. The new divisor is then loaded and the stable flag drops. The internal divider is given a settle interval. The bus clock runs again only once the flag is back. This sequence keeps short or torn pulses away from the card, whatever order software writes the fields in. A divisor of 0 or 1 selects the reference clock directly.

A timeout counter measures how long the card keeps a transfer or busy phase open. While the busy-wait input is high, the counter counts card clock edges. It flags a timeout after a power-of-two number of them, chosen by the timeout code.

Top module: `card_clk_divider`

## Requirements
- R1: The control word has the internal-clock enable at bit 0, the bus-clock enable at bit 2, the divisor at bits [6 +: DIV_W] and the 4-bit timeout code at bits [19:16]. A write with `reg_we` high loads all fields at once. `reg_rdata` returns these fields, with the stable flag at bit 1 and zeros in all other bits. After reset every field reads 0.
- R2: Setting the internal-clock enable raises `clk_stable` between SETTLE_CYC and SETTLE_CYC+2 reference cycles after the write edge. Clearing it lowers `clk_stable` within two cycles and stops the card clock.
- R3: When the divisor D is 2 or more, `card_clk` has one rising edge every D reference cycles.
- R4: When the divisor is 0 or 1, `card_clk` follows the reference clock, with one rising edge per reference cycle.
- R5: `card_clk` stays low while the bus-clock enable is clear.
- R6: A new divisor written while the bus clock runs first stops the card clock. The new value is loaded only after the clock has stopped, which lowers `clk_stable`. No card clock edge occurs while `clk_stable` is low. The clock then resumes at the new rate.
- R7: `card_clk` never produces a high or low pulse shorter than half a reference period. The gate opens and closes only while the divided clock is low.
- R8: While `busy_wait` is high, `timeout_hit` rises after 2^(TO_BASE+code) card clock rising edges and stays high. It clears once `busy_wait` falls. While the card clock is gated, the counter does not advance.
- R9: A bus-clock enable written together with, or before, the internal-clock enable produces no card clock edge until `clk_stable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write value |
| reg_rdata | output | 32 | Control word read value with stable flag |
| busy_wait | input | 1 | High while a data/busy phase is being timed |
| card_clk | output | 1 | Gated card bus clock |
| clk_stable | output | 1 | Internal clock stable flag |
| timeout_hit | output | 1 | Data/busy timeout reached |

## Verification
The bench builds the block with SETTLE_CYC = 4, TO_BASE = 2 and the default DIV_W = 10. The short settle interval keeps each divisor change to a few dozen cycles, so the bench can check the identification divisor of 240, the bypass divisors and odd divisors in one run. With TO_BASE = 2, a timeout code of 0 gives a limit of four card clocks and a code of 2 gives sixteen, so the timeout is reached within tens of cycles. The bench records every card clock pulse width throughout the run, which exposes any glitch at a gating or divisor transition.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_RUN    = 2'd2,
        SEQ_DRAIN  = 2'd3
    } seq_state_e;

    localparam int F_INT_EN   = 0;
    localparam int F_STABLE   = 1;
    localparam int F_BUS_EN   = 2;
    localparam int F_DIV_LSB  = 6;
    localparam int F_TMO_LSB  = 16;
    localparam int TMO_CODE_W = 4;

endpackage

// File: rtl/ckdiv_seq.sv
module ckdiv_seq
    import ckdiv_pkg::*;
#(
    parameter int DIV_W      = 10,
    parameter int SETTLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_en,
    input  logic             bus_en,
    input  logic [DIV_W-1:0] div_req,
    input  logic             gate_open,
    output logic [DIV_W-1:0] div_act,
    output logic             restart,
    output logic             run,
    output logic             gate_want,
    output logic             stable
);
    localparam int SCW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [SCW-1:0]   cnt;
        logic [DIV_W-1:0] div;
    } seq_t;

    seq_t s_d, s_q;
    logic load;

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        case (s_q.state)
            SEQ_OFF: begin
                if (int_en) load = 1'b1;
            end
            SEQ_SETTLE: begin
                if (s_q.cnt == SCW'(SETTLE_CYC - 1)) begin
                    s_d.state = SEQ_RUN;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + SCW'(1);
                end
            end
            SEQ_RUN: begin
                if (div_req != s_q.div) begin
                    if (!gate_open) load = 1'b1;
                    else            s_d.state = SEQ_DRAIN;
                end
            end
            default: begin
                if (!gate_open) load = 1'b1;
            end
        endcase
        if (load) begin
            s_d.div   = div_req;
            s_d.cnt   = '0;
            s_d.state = SEQ_SETTLE;
        end
        if (!int_en) begin
            s_d.state = SEQ_OFF;
            s_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: SEQ_OFF, cnt: '0, div: '0};
        else        s_q <= s_d;
    end

    assign restart   = load & int_en;
    assign run       = (s_q.state != SEQ_OFF);
    assign stable    = (s_q.state == SEQ_RUN);
    assign div_act   = s_q.div;
    assign gate_want = (s_q.state == SEQ_RUN) && int_en && bus_en
                       && (div_req == s_q.div);

endmodule

// File: rtl/ckdiv_gen.sv
module ckdiv_gen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    input  logic             gate_want,
    output logic             gate_open,
    output logic             gate_en,
    output logic             raw_lvl,
    output logic             bypass,
    output logic             tick,
    output logic             card_clk
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             raw;
        logic             rise;
        logic             gate;
    } gen_t;

    gen_t g_d, g_q;
    logic en_q;
    logic [DIV_W-1:0] half;

    assign bypass = (div < DIV_W'(2));
    assign half   = div >> 1;

    always_comb begin
        g_d = g_q;
        if (!run || restart || bypass)
            g_d.cnt = '0;
        else if (g_q.cnt == div - DIV_W'(1))
            g_d.cnt = '0;
        else
            g_d.cnt = g_q.cnt + DIV_W'(1);
        g_d.raw  = run && !restart && !bypass && (g_d.cnt >= half);
        g_d.rise = g_d.raw && !g_q.raw;
        // gate may only move while the divided clock will be low
        if (bypass || !g_d.raw) g_d.gate = gate_want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    // enable retimed on the falling edge: changes only while clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= g_q.gate;
    end

    assign card_clk  = en_q & (bypass ? clk : g_q.raw);
    assign tick      = en_q & (bypass | g_q.rise);
    assign gate_open = g_q.gate;
    assign gate_en   = en_q;
    assign raw_lvl   = g_q.raw;

endmodule

// File: rtl/ckdiv_tmo.sv
module ckdiv_tmo #(
    parameter int TO_BASE = 13,
    parameter int CODE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_on,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    localparam int CW = TO_BASE + (1 << CODE_W);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hit;
    } tmo_t;

    tmo_t t_d, t_q;
    logic [CW-1:0] limit;

    assign limit = CW'(1) << (TO_BASE + int'(code));

    always_comb begin
        t_d = t_q;
        if (!wait_on) begin
            t_d.cnt = '0;
            t_d.hit = 1'b0;
        end else if (tick && !t_q.hit) begin
            t_d.cnt = t_q.cnt + CW'(1);
            if (t_q.cnt + CW'(1) == limit) t_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign hit = t_q.hit;

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
    import ckdiv_pkg::*;
#(
    parameter int DIV_W      = 10,
    parameter int SETTLE_CYC = 16,
    parameter int TO_BASE    = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy_wait,
    output logic        card_clk,
    output logic        clk_stable,
    output logic        timeout_hit
);
    typedef struct packed {
        logic                  int_en;
        logic                  bus_en;
        logic [DIV_W-1:0]      div;
        logic [TMO_CODE_W-1:0] code;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [DIV_W-1:0] div_act;
    logic restart, run, gate_want, gate_open, gate_en;
    logic raw_lvl, div_bypass, tick;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            cfg_d.int_en = reg_wdata[F_INT_EN];
            cfg_d.bus_en = reg_wdata[F_BUS_EN];
            cfg_d.div    = reg_wdata[F_DIV_LSB +: DIV_W];
            cfg_d.code   = reg_wdata[F_TMO_LSB +: TMO_CODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        reg_rdata[F_INT_EN]                 = cfg_q.int_en;
        reg_rdata[F_STABLE]                 = clk_stable;
        reg_rdata[F_BUS_EN]                 = cfg_q.bus_en;
        reg_rdata[F_DIV_LSB +: DIV_W]       = cfg_q.div;
        reg_rdata[F_TMO_LSB +: TMO_CODE_W]  = cfg_q.code;
    end

    ckdiv_seq #(.DIV_W(DIV_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_en    (cfg_q.int_en),
        .bus_en    (cfg_q.bus_en),
        .div_req   (cfg_q.div),
        .gate_open (gate_open),
        .div_act   (div_act),
        .restart   (restart),
        .run       (run),
        .gate_want (gate_want),
        .stable    (clk_stable)
    );

    ckdiv_gen #(.DIV_W(DIV_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (restart),
        .div       (div_act),
        .gate_want (gate_want),
        .gate_open (gate_open),
        .gate_en   (gate_en),
        .raw_lvl   (raw_lvl),
        .bypass    (div_bypass),
        .tick      (tick),
        .card_clk  (card_clk)
    );

    ckdiv_tmo #(.TO_BASE(TO_BASE), .CODE_W(TMO_CODE_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_on (busy_wait),
        .tick    (tick),
        .code    (cfg_q.code),
        .hit     (timeout_hit)
    );

endmodule

// File: rtl/card_clk_divider_chk.sv
module card_clk_divider_chk #(
    parameter int DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_en,
    input logic             stable,
    input logic             gate_open,
    input logic             gate_en,
    input logic             raw_lvl,
    input logic             bypass,
    input logic [DIV_W-1:0] div_act,
    input logic             busy_wait,
    input logic             timeout_hit
);
    // R6
    div_load_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_act != $past(div_act)) |-> !$past(gate_en));

    // R9
    open_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> $past(stable));

    // R7
    low_phase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_open != $past(gate_open)) && !bypass) |-> !raw_lvl);

    // R2
    int_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !stable);

    // R8
    tmo_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |-> $past(busy_wait));

endmodule

bind card_clk_divider card_clk_divider_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_en      (cfg_q.int_en),
    .stable      (clk_stable),
    .gate_open   (gate_open),
    .gate_en     (gate_en),
    .raw_lvl     (raw_lvl),
    .bypass      (div_bypass),
    .div_act     (div_act),
    .busy_wait   (busy_wait),
    .timeout_hit (timeout_hit)
);

// File: tb/card_clk_divider_bench.sv
`timescale 1ns/1ps
module card_clk_divider_bench;
    localparam int SETTLE = 4;
    localparam int TOB    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy_wait = 1'b0;
    logic        card_clk, clk_stable, timeout_hit;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    int cyc    = 0;
    realtime t_rise = 0.0, t_fall = 0.0;
    realtime min_hi = 1.0e9, min_lo = 1.0e9;
    bit seen_rise = 0, seen_fall = 0;

    always #2.5 clk = ~clk;

    card_clk_divider #(.DIV_W(10), .SETTLE_CYC(SETTLE), .TO_BASE(TOB)) u_card_clk_divider (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy_wait(busy_wait), .card_clk(card_clk),
        .clk_stable(clk_stable), .timeout_hit(timeout_hit)
    );

    always @(posedge card_clk) begin
        edges++;
        if (seen_fall && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
        t_rise = $realtime; seen_rise = 1;
    end
    always @(negedge card_clk) begin
        if (seen_rise && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
        t_fall = $realtime; seen_fall = 1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit ie, input bit be, input int dv, input int code);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = 32'(ie) | (32'(be) << 2) | (32'(dv) << 6) | (32'(code) << 16);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // polls until clk_stable equals val; returns cycles waited
    task automatic wait_stable(input bit val, input int max, output int n);
        n = 1;
        while (clk_stable !== val && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic edges_over(input int ncyc, output int n);
        int e0;
        e0 = edges;
        repeat (ncyc) @(negedge clk);
        n = edges - e0;
    endtask

    task automatic t_reset();
        chk(reg_rdata == 32'h0, "R1 reset rdata", reg_rdata, 0);
        chk(card_clk == 1'b0, "R5 reset card_clk", card_clk, 0);
        chk(clk_stable == 1'b0, "R2 reset stable", clk_stable, 0);
        chk(timeout_hit == 1'b0, "R8 reset timeout", timeout_hit, 0);
    endtask

    task automatic t_enable();
        int n;
        wr(1, 0, 4, 0);
        wait_stable(1, 60, n);
        chk(n >= SETTLE && n <= SETTLE + 2, "R2 settle cycles", n, SETTLE);
        chk(reg_rdata == 32'h103, "R1 readback", reg_rdata, 32'h103);
        edges_over(60, n);
        chk(n == 0, "R5 bus disabled edges", n, 0);
    endtask

    task automatic t_rate(input int dv, input string req);
        int n, w, exp;
        wr(1, 1, dv, 0);
        repeat (2) @(negedge clk);
        wait_stable(1, 2000, w);
        repeat (2 * dv + 6) @(negedge clk);
        edges_over(960, n);
        exp = (dv < 2) ? 960 : 960 / dv;
        chk(n >= exp - 1 && n <= exp + 1, req, n, exp);
    endtask

    task automatic t_change();
        int n, w, e0;
        wr(1, 1, 4, 0);
        wait_stable(1, 200, w);
        repeat (20) @(negedge clk);
        wr(1, 1, 8, 0);
        wait_stable(0, 30, w);
        chk(clk_stable == 1'b0, "R6 stable drops on change", clk_stable, 0);
        e0 = edges;
        wait_stable(1, 200, w);
        chk(edges == e0, "R6 no edges while unstable", edges - e0, 0);
        repeat (22) @(negedge clk);
        edges_over(960, n);
        chk(n >= 119 && n <= 121, "R6 new rate", n, 120);
    endtask

    task automatic t_early_bus();
        int w, e0;
        wr(0, 0, 4, 0);
        repeat (4) @(negedge clk);
        e0 = edges;
        wr(1, 1, 4, 0);
        wait_stable(1, 200, w);
        chk(edges == e0, "R9 no edge before stable", edges - e0, 0);
        repeat (12) @(negedge clk);
        chk(edges > e0, "R9 clock starts after stable", edges - e0, 1);
    endtask

    task automatic t_off();
        int n;
        wr(0, 1, 4, 0);
        repeat (2) @(negedge clk);
        chk(clk_stable == 1'b0, "R2 stable drops on disable", clk_stable, 0);
        repeat (10) @(negedge clk);
        edges_over(60, n);
        chk(n == 0, "R2 clock stops on disable", n, 0);
    endtask

    task automatic t_tmo(input int dv, input int code);
        int w, e0, n, lim;
        lim = 1 << (TOB + code);
        wr(1, 1, dv, code);
        wait_stable(1, 200, w);
        repeat (2 * dv + 6) @(negedge clk);
        busy_wait = 1'b1;
        e0 = edges;
        w = 0;
        while (!timeout_hit && w < 400) begin
            @(negedge clk);
            w++;
        end
        n = edges - e0;
        chk(timeout_hit && n >= lim - 1 && n <= lim + 1, "R8 timeout edge count", n, lim);
        repeat (5) @(negedge clk);
        chk(timeout_hit == 1'b1, "R8 timeout sticky", timeout_hit, 1);
        busy_wait = 1'b0;
        repeat (2) @(negedge clk);
        chk(timeout_hit == 1'b0, "R8 timeout clears", timeout_hit, 0);
    endtask

    task automatic t_tmo_gated();
        wr(1, 0, 4, 0);
        repeat (30) @(negedge clk);
        busy_wait = 1'b1;
        repeat (100) @(negedge clk);
        chk(timeout_hit == 1'b0, "R8 no count while gated", timeout_hit, 0);
        busy_wait = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_rate(4, "R3 divide by 4");
        t_rate(2, "R3 divide by 2");
        t_rate(3, "R3 divide by 3");
        t_rate(240, "R3 divide by 240");
        t_rate(0, "R4 bypass with 0");
        t_rate(1, "R4 bypass with 1");
        t_change();
        t_early_bus();
        t_off();
        t_tmo(2, 0);
        t_tmo(4, 2);
        t_tmo_gated();
        chk(min_hi >= 2.4, "R7 min high pulse ps", longint'(min_hi * 1000), 2500);
        chk(min_lo >= 2.4, "R7 min low pulse ps", longint'(min_lo * 1000), 2500);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule